// File: doc/BRIEF.md
# Run/Stop Switch Fault-Clear Sequencer

This block decides the operating mode of a controller from a two-position Run/Stop switch and a fatal-fault flag. With no fatal fault present, moving the switch from Stop to Run enters Run mode at once. Any non-fatal faults stay where they are, because no clear is issued. Moving the switch back to Stop, or a fatal fault arriving, returns the controller to Stop.

When a fatal fault holds the controller stopped, a Stop-to-Run move does not start the controller. It opens a timed recovery window, and the Run indicator blinks while the window is open. Inside the window the operator must hold Run for a minimum dwell, then hold Stop for the same dwell, then return to Run. Completing that toggle issues a one-cycle fault-clear pulse, enters Run and turns the indicator on steadily. If the window runs out first, the controller stays stopped and the indicator goes dark. A later Stop-to-Run move opens a fresh window.

All timing is counted on a slow strobe from an external prescaler, one pulse per millisecond by default. A separate enable input can take the switch out of the picture entirely.

Top module: `mode_fault_seq`

## Requirements
- R1: After reset `mode_run`, `fault_clr` and `run_led` are 0. The switch is taken to be at Run during reset, so only a Stop-to-Run move made after reset counts as a Run request.
- R2: While stopped with `sw_en`=1 and `fault_fatal`=0, a move of `sw_run` from 0 (Stop) to 1 (Run) sets `mode_run` to 1 on the next clock edge. `fault_clr` stays 0.
- R3: In Run, `sw_run` going to 0 while `sw_en`=1 returns `mode_run` to 0 on the next edge. `fault_fatal`=1 does the same regardless of `sw_en`.
- R4: While stopped with `fault_fatal`=1, a Stop-to-Run move keeps `mode_run` at 0 and opens the recovery window. During the window `run_led` equals the inverse of bit BLINK_SHIFT of the tick count since the window opened. It therefore starts at 1 and alternates every 2^BLINK_SHIFT ticks.
- R5: Inside the window, the following sequence sets `mode_run` to 1, and `run_led` is then held at 1. First the switch stays at Run for at least DWELL_TICKS ticks. Then it stays at Stop for at least DWELL_TICKS ticks. Then it returns to Run.
- R6: A dwell shorter than DWELL_TICKS aborts the gesture without closing the window. Leaving Run early means waiting for Run again. Returning to Run early restarts the Run dwell.
- R7: If WINDOW_TICKS ticks pass in the window without the gesture being completed, the window closes. `mode_run` stays 0, `run_led` goes to 0 and `fault_clr` stays 0.
- R8: After a window has closed, a new Stop-to-Run move opens a new window in which the gesture can succeed.
- R9: With `sw_en`=0, switch moves never change `mode_run`, and an open window is dropped, with `run_led` going to 0.
- R10: `fault_clr` is high for exactly one cycle, and only in the first cycle of Run entered through a completed gesture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timing strobe from the prescaler |
| sw_run | input | 1 | Debounced switch level, 1 = Run position |
| sw_en | input | 1 | 1 = switch may change the mode |
| fault_fatal | input | 1 | 1 = a fatal fault is recorded |
| mode_run | output | 1 | 1 = controller in Run mode |
| fault_clr | output | 1 | One-cycle request to clear the fault table |
| run_led | output | 1 | Run indicator drive |

## Verification
The bench targets the dwell boundaries. If a design counted the dwell from the window start instead of from the last switch move, it would accept an early Stop and clear faults too soon. If it reset the window timer on an aborted gesture, it would let the operator retry forever.

Timeout is checked with the switch left at Run. A design that treated the switch level as a request, rather than its movement, would reopen the window immediately instead of waiting for a fresh Stop-to-Run move.

Disabling the switch mid-window and mid-Run exposes designs that latch a stale edge. Such a design would change mode once the enable returns. A fatal fault arriving together with the clear pulse shows whether the pulse is tied to the Run entry cycle alone.

// File: rtl/msw_pkg.sv
package msw_pkg;

    typedef enum logic [2:0] {
        MS_STOP      = 3'd0,
        MS_RUN       = 3'd1,
        MS_HOLD_RUN  = 3'd2,
        MS_HOLD_STOP = 3'd3,
        MS_REARM     = 3'd4
    } ms_state_e;

    typedef struct packed {
        ms_state_e state;
        logic      clr;
    } ms_ctl_s;

endpackage

// File: rtl/msw_edge.sv
module msw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
        rise  = lvl & ~lvl_q;
        fall  = ~lvl & lvl_q;
    end

    // The switch is assumed to sit at Run during reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_d;
    end

endmodule

// File: rtl/msw_tick_cnt.sv
module msw_tick_cnt #(
    parameter int MAX = 500
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         tick,
    output logic [$clog2(MAX+1)-1:0]     cnt
);

    localparam int W = $clog2(MAX + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (tick && cnt_q < W'(MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == '0 || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/mode_fault_seq.sv
module mode_fault_seq
    import msw_pkg::*;
#(
    parameter int DWELL_TICKS  = 500,
    parameter int WINDOW_TICKS = 5000,
    parameter int BLINK_SHIFT  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sw_run,
    input  logic sw_en,
    input  logic fault_fatal,
    output logic mode_run,
    output logic fault_clr,
    output logic run_led
);

    localparam int DW = $clog2(DWELL_TICKS + 1);
    localparam int WW = $clog2(WINDOW_TICKS + 1);

    logic          rise, fall;
    logic [DW-1:0] dwell_cnt;
    logic [WW-1:0] win_cnt;
    logic          dwell_clr, win_clr;
    logic          dwell_ok, win_done, in_window;
    ms_ctl_s       st_d, st_q;

    msw_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sw_run),
        .rise (rise),
        .fall (fall)
    );

    msw_tick_cnt #(.MAX(DWELL_TICKS)) u_dwell (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (dwell_clr),
        .tick (tick),
        .cnt  (dwell_cnt)
    );

    msw_tick_cnt #(.MAX(WINDOW_TICKS)) u_window (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (win_clr),
        .tick (tick),
        .cnt  (win_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.clr  = 1'b0;
        dwell_ok  = dwell_cnt >= DW'(DWELL_TICKS);
        win_done  = win_cnt >= WW'(WINDOW_TICKS);
        in_window = (st_q.state == MS_HOLD_RUN) || (st_q.state == MS_HOLD_STOP) ||
                    (st_q.state == MS_REARM);

        unique case (st_q.state)
            MS_STOP: begin
                if (sw_en && rise)
                    st_d.state = fault_fatal ? MS_HOLD_RUN : MS_RUN;
            end
            MS_RUN: begin
                if (fault_fatal || (sw_en && fall))
                    st_d.state = MS_STOP;
            end
            MS_HOLD_RUN: begin
                if (!sw_en)        st_d.state = MS_STOP;
                else if (fall)     st_d.state = dwell_ok ? MS_HOLD_STOP : MS_REARM;
                else if (win_done) st_d.state = MS_STOP;
            end
            MS_HOLD_STOP: begin
                if (!sw_en) st_d.state = MS_STOP;
                else if (rise) begin
                    if (dwell_ok) begin
                        st_d.state = MS_RUN;
                        st_d.clr   = 1'b1;
                    end else begin
                        st_d.state = MS_HOLD_RUN;
                    end
                end else if (win_done) st_d.state = MS_STOP;
            end
            MS_REARM: begin
                if (!sw_en)        st_d.state = MS_STOP;
                else if (rise)     st_d.state = MS_HOLD_RUN;
                else if (win_done) st_d.state = MS_STOP;
            end
            default: st_d.state = MS_STOP;
        endcase

        win_clr   = !in_window;
        dwell_clr = !in_window || (st_d.state != st_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: MS_STOP, clr: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_run  = (st_q.state == MS_RUN);
    assign fault_clr = st_q.clr;
    assign run_led   = (st_q.state == MS_RUN) ? 1'b1 :
                       in_window ? ~win_cnt[BLINK_SHIFT] : 1'b0;

    AST_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |-> st_q.state == MS_RUN); // R10
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |=> !st_q.clr); // R10
    AST_PLAIN_STOP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == MS_STOP |=> !st_q.clr); // R2
    AST_FATAL_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == MS_STOP && fault_fatal) |=> st_q.state != MS_RUN); // R4
    AST_RUN_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == MS_RUN && sw_en && fall) |=> st_q.state == MS_STOP); // R3
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && st_q.state != MS_RUN) |=> st_q.state == MS_STOP); // R9
    AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> win_cnt <= WW'(WINDOW_TICKS)); // R7

endmodule

// File: tb/tb_mode_fault_seq.sv
module tb_mode_fault_seq;

    localparam int D   = 8;
    localparam int WIN = 64;
    localparam int SH  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sw_run = 1'b1;
    logic sw_en = 1'b1;
    logic fault_fatal = 1'b0;
    logic mode_run, fault_clr, run_led;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    mode_fault_seq #(.DWELL_TICKS(D), .WINDOW_TICKS(WIN), .BLINK_SHIFT(SH)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sw_run(sw_run), .sw_en(sw_en),
        .fault_fatal(fault_fatal), .mode_run(mode_run), .fault_clr(fault_clr),
        .run_led(run_led)
    );

    // Reference model: 0 stop, 1 run, 2 hold run, 3 hold stop, 4 wait for run
    int m_st = 0;
    int m_dw = 0;
    int m_wn = 0;
    bit m_clr = 0;
    bit m_psw = 1;

    function automatic bit win_state(int s);
        return s >= 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_dw = 0; m_wn = 0; m_clr = 0; m_psw = 1;
        end else begin
            bit r, f, ok, done;
            int ns;
            r = sw_run && !m_psw;
            f = !sw_run && m_psw;
            ok = m_dw >= D;
            done = m_wn >= WIN;
            ns = m_st;
            m_clr = 0;
            if (m_st == 0) begin
                if (sw_en && r) ns = fault_fatal ? 2 : 1;
            end else if (m_st == 1) begin
                if (fault_fatal || (sw_en && f)) ns = 0;
            end else if (!sw_en) begin
                ns = 0;
            end else if (m_st == 2) begin
                if (f) ns = ok ? 3 : 4; else if (done) ns = 0;
            end else if (m_st == 3) begin
                if (r) begin
                    if (ok) begin ns = 1; m_clr = 1; end else ns = 2;
                end else if (done) ns = 0;
            end else begin
                if (r) ns = 2; else if (done) ns = 0;
            end
            if (!win_state(m_st) || ns != m_st) m_dw = 0;
            else if (tick && m_dw < D) m_dw++;
            if (!win_state(m_st)) m_wn = 0;
            else if (tick && m_wn < WIN) m_wn++;
            m_st = ns;
            m_psw = sw_run;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick <= (cyc % 4 == 0);
        if (rst_n) begin
            bit eled;
            eled = (m_st == 1) ? 1'b1 : win_state(m_st) ? (((m_wn >> SH) & 1) == 0) : 1'b0;
            chk(mode_run == (m_st == 1), {cur_req, " model mode"}, mode_run, m_st == 1);
            chk(fault_clr == m_clr, {cur_req, " model clr"}, fault_clr, m_clr);
            chk(run_led == eled, {cur_req, " model led"}, run_led, eled);
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gesture_tail();
        step(60);
        sw_run = 1'b0;
        step(48);
        sw_run = 1'b1;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(5);
        chk(mode_run == 0, "R1 mode after reset", mode_run, 0);
        chk(run_led == 0, "R1 led after reset", run_led, 0);
        chk(fault_clr == 0, "R1 clr after reset", fault_clr, 0);

        cur_req = "R2";
        sw_run = 1'b0; step(3);
        sw_run = 1'b1; step(1);
        chk(mode_run == 1, "R2 run without fatal", mode_run, 1);
        chk(fault_clr == 0, "R2 no clear", fault_clr, 0);

        cur_req = "R3";
        sw_run = 1'b0; step(1);
        chk(mode_run == 0, "R3 switch to stop", mode_run, 0);
        sw_run = 1'b1; step(2);
        fault_fatal = 1'b1; step(1);
        chk(mode_run == 0, "R3 fatal stops run", mode_run, 0);
        sw_run = 1'b0; step(2);

        cur_req = "R4";
        sw_run = 1'b1; step(1);
        chk(mode_run == 0, "R4 fatal holds stop", mode_run, 0);
        chk(run_led == 1, "R4 led starts on", run_led, 1);
        step(20);
        chk(run_led == 0, "R4 led blinks off", run_led, 0);
        cur_req = "R5";
        step(40);
        sw_run = 1'b0; step(1);
        chk(mode_run == 0, "R5 still stopped mid gesture", mode_run, 0);
        step(48);
        sw_run = 1'b1; step(1);
        chk(mode_run == 1, "R5 gesture enters run", mode_run, 1);
        chk(run_led == 1, "R5 led steady", run_led, 1);
        chk(fault_clr == 1, "R10 pulse with run entry", fault_clr, 1);
        fault_fatal = 1'b0; step(1);
        chk(fault_clr == 0, "R10 pulse one cycle", fault_clr, 0);
        sw_run = 1'b0; step(2);

        cur_req = "R6";
        fault_fatal = 1'b1;
        sw_run = 1'b1; step(9);
        sw_run = 1'b0; step(1);
        chk(mode_run == 0, "R6 early stop aborts", mode_run, 0);
        step(4);
        sw_run = 1'b1; step(1);
        gesture_tail();
        chk(mode_run == 1, "R6 success after rearm", mode_run, 1);
        fault_fatal = 1'b0;
        sw_run = 1'b0; step(2);

        fault_fatal = 1'b1;
        sw_run = 1'b1; step(60);
        sw_run = 1'b0; step(8);
        sw_run = 1'b1; step(1);
        chk(mode_run == 0, "R6 early return restarts", mode_run, 0);
        gesture_tail();
        chk(mode_run == 1, "R6 success after restart", mode_run, 1);
        fault_fatal = 1'b0;
        sw_run = 1'b0; step(2);

        cur_req = "R7";
        fault_fatal = 1'b1;
        sw_run = 1'b1; step(300);
        chk(mode_run == 0, "R7 timeout keeps stop", mode_run, 0);
        chk(run_led == 0, "R7 led off after timeout", run_led, 0);
        chk(fault_clr == 0, "R7 no clear on timeout", fault_clr, 0);

        cur_req = "R8";
        sw_run = 1'b0; step(4);
        sw_run = 1'b1; step(1);
        chk(run_led == 1, "R8 new window opens", run_led, 1);
        gesture_tail();
        chk(mode_run == 1, "R8 retry succeeds", mode_run, 1);
        fault_fatal = 1'b0;
        sw_run = 1'b0; step(2);

        cur_req = "R9";
        sw_en = 1'b0;
        sw_run = 1'b1; step(3);
        chk(mode_run == 0, "R9 disabled ignores run move", mode_run, 0);
        sw_run = 1'b0; step(2);
        sw_en = 1'b1;
        sw_run = 1'b1; step(2);
        sw_en = 1'b0;
        sw_run = 1'b0; step(3);
        chk(mode_run == 1, "R9 disabled ignores stop move", mode_run, 1);
        sw_en = 1'b1; step(2);
        chk(mode_run == 1, "R9 no stale edge", mode_run, 1);
        sw_run = 1'b1; step(2);
        sw_run = 1'b0; step(2);
        fault_fatal = 1'b1;
        sw_run = 1'b1; step(1);
        sw_en = 1'b0; step(2);
        chk(run_led == 0, "R9 window dropped", run_led, 0);
        chk(mode_run == 0, "R9 stays stopped", mode_run, 0);
        sw_en = 1'b1;
        fault_fatal = 1'b0;
        step(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule